// File: doc/BRIEF.md
# Alternating Double-Buffer Receive Object

This block is the catch-all receive slot of a CAN controller: every frame that no other slot accepted is stored here. Data and remote frames, with 11-bit or 29-bit identifiers, are all handled. Two physical buffers sit behind one CPU-visible register view. A new frame always lands in a free buffer while the CPU reads the other one. A burst of back-to-back frames therefore does not corrupt the contents the CPU is reading.

The CPU controls the slot through one control write made of 2-bit set/clear fields. When a single write clears both the new-data flag and the remote-pending flag, the buffer in view is released. The view then moves to the buffer that holds the newest frame, and the next frame goes into the buffer just freed. The pending flag of the buffer now in view stays set until a separate write clears it. The receive interrupt request is gated by a receive-enable bit. If a frame arrives while both buffers are allocated, the buffer not in view is overwritten and a message-lost flag is raised.

Top module: `rxobj_dualbuf`

## Requirements
- R1: After reset both buffers are released, and view_newdat, view_rmtpnd, view_intpnd, msg_lost and rx_irq are 0, with view_id and view_data at 0.
- R2: A store copies identifier, format, remote flag, length and data into the receiving buffer, sets its new-data and pending flags, and sets its remote-pending flag exactly when store_rtr is 1.
- R3: When both buffers are released, a stored frame goes into the buffer in view and is visible on the view outputs one cycle after the strobe.
- R4: When the buffer in view is allocated and the other is free, a stored frame goes into the other buffer, and the view outputs are unchanged.
- R5: A control write whose new-data field ([11:10]) and remote-pending field ([9:8]) are both 01 releases the buffer in view. The view moves to the other buffer if that buffer is allocated. The pending field of the same write ([1:0]) applies to the buffer that was in view.
- R6: After a release, the pending flag of the buffer newly in view stays 1 until a write with pending field 01 clears it.
- R7: After a release, the next stored frame goes into the freed buffer, and the view outputs are unchanged.
- R8: A frame that arrives while both buffers are allocated overwrites the buffer not in view and sets msg_lost. msg_lost is cleared by a write with field [7:6] = 01.
- R9: rx_irq is 1 exactly when the receive-enable bit (field [3:2]) is set and either buffer's pending flag is 1. The transmit-enable bit (field [5:4]) has no effect on rx_irq.
- R10: In every 2-bit control field, 01 clears the bit, 10 sets it, and 00 or 11 keep it. A write that clears only the new-data flag releases nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| store_en | input | 1 | Strobe: store the frame on the store_* inputs |
| store_id | input | 29 | Frame identifier |
| store_ext | input | 1 | 1 = extended identifier |
| store_rtr | input | 1 | 1 = remote frame |
| store_dlc | input | 4 | Data length code |
| store_data | input | 64 | Data bytes |
| ctl_wr | input | 1 | CPU control write strobe |
| ctl_wdata | input | 12 | Set/clear fields: [1:0] pending, [3:2] rx enable, [5:4] tx enable, [7:6] msg lost, [9:8] remote pending, [11:10] new data |
| view_id | output | 29 | Identifier of the buffer in view |
| view_ext | output | 1 | Format bit of the buffer in view |
| view_rtr | output | 1 | Remote bit of the buffer in view |
| view_dlc | output | 4 | Length of the buffer in view |
| view_data | output | 64 | Data of the buffer in view |
| view_newdat | output | 1 | New-data flag of the buffer in view |
| view_rmtpnd | output | 1 | Remote-pending flag of the buffer in view |
| view_intpnd | output | 1 | Pending flag of the buffer in view |
| msg_lost | output | 1 | A frame overwrote an unread buffer |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Every cycle, the assertions check the following. A store sets the receiving buffer's flags. An idle buffer holds its contents. At most one buffer is loaded, and never the one in view while it is allocated. A release moves the view when the other buffer is allocated. A store into a full object raises msg_lost. An enabled store raises rx_irq. Only the directed scenarios can show the buffer order a sequence of stores and releases produces, which frame ends up in view after an overwrite, and that a write clearing only the new-data flag keeps both buffers in place.

// File: rtl/rxobj_pkg.sv
package rxobj_pkg;

  localparam int CTL_W    = 12;
  localparam int POS_PEND = 0;
  localparam int POS_RXEN = 2;
  localparam int POS_TXEN = 4;
  localparam int POS_LOST = 6;
  localparam int POS_RMT  = 8;
  localparam int POS_NEW  = 10;

  typedef enum logic [1:0] {
    FLD_HOLD0 = 2'b00,
    FLD_CLR   = 2'b01,
    FLD_SET   = 2'b10,
    FLD_HOLD  = 2'b11
  } fld_t;

  function automatic logic fld_apply(input logic cur, input logic [1:0] f);
    case (fld_t'(f))
      FLD_CLR: fld_apply = 1'b0;
      FLD_SET: fld_apply = 1'b1;
      default: fld_apply = cur;
    endcase
  endfunction

endpackage

// File: rtl/rxobj_rst_sync.sv
module rxobj_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rxobj_slot.sv
module rxobj_slot
  import rxobj_pkg::*;
#(
  parameter int PAY_W = 99
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [PAY_W-1:0] ld_pay,
  input  logic             ld_rmt,
  input  logic             wr_en,
  input  logic [1:0]       f_new,
  input  logic [1:0]       f_rmt,
  input  logic [1:0]       f_pend,
  output logic [PAY_W-1:0] pay_q,
  output logic             new_q,
  output logic             rmt_q,
  output logic             pend_q
);

  logic [PAY_W-1:0] pay_n;
  logic             new_n, rmt_n, pend_n;

  always_comb begin
    pay_n  = pay_q;
    new_n  = new_q;
    rmt_n  = rmt_q;
    pend_n = pend_q;
    if (ld_en) begin
      pay_n  = ld_pay;
      new_n  = 1'b1;
      pend_n = 1'b1;
      rmt_n  = ld_rmt;
    end else if (wr_en) begin
      new_n  = fld_apply(new_q, f_new);
      rmt_n  = fld_apply(rmt_q, f_rmt);
      pend_n = fld_apply(pend_q, f_pend);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q  <= '0;
      new_q  <= 1'b0;
      rmt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ld_en) pay_q <= pay_n;
      if (ld_en || wr_en) begin
        new_q  <= new_n;
        rmt_q  <= rmt_n;
        pend_q <= pend_n;
      end
    end
  end

  assert_store_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (new_q && pend_q && (rmt_q == $past(ld_rmt)) && (pay_q == $past(ld_pay))));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !wr_en) |=> ($stable(pay_q) && $stable(new_q) && $stable(rmt_q) && $stable(pend_q)));

endmodule

// File: rtl/rxobj_ctl.sv
module rxobj_ctl
  import rxobj_pkg::*;
#(
  parameter int NBUF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             view_q,
  output logic [NBUF-1:0]  ld_sel,
  output logic [NBUF-1:0]  wr_sel,
  output logic             lost_q,
  output logic             rxen_q
);

  logic [NBUF-1:0] alloc_q, alloc_w, alloc_n;
  logic            view_w, view_n, tgt, both, rel;
  logic            lost_n, rxen_n, txen_q, txen_n;

  always_comb begin
    rel = ctl_wr
          && (fld_t'(ctl_wdata[POS_NEW +: 2]) == FLD_CLR)
          && (fld_t'(ctl_wdata[POS_RMT +: 2]) == FLD_CLR);
    alloc_w = alloc_q;
    view_w  = view_q;
    if (rel) begin
      alloc_w[view_q] = 1'b0;
      if (alloc_q[~view_q]) view_w = ~view_q;
    end
    tgt     = alloc_w[view_w] ? ~view_w : view_w;
    both    = &alloc_w;
    alloc_n = alloc_w;
    ld_sel  = '0;
    if (store_en) begin
      alloc_n[tgt] = 1'b1;
      ld_sel[tgt]  = 1'b1;
    end
    view_n = view_w;
    lost_n = lost_q;
    rxen_n = rxen_q;
    txen_n = txen_q;
    if (ctl_wr) begin
      lost_n = fld_apply(lost_q, ctl_wdata[POS_LOST +: 2]);
      rxen_n = fld_apply(rxen_q, ctl_wdata[POS_RXEN +: 2]);
      txen_n = fld_apply(txen_q, ctl_wdata[POS_TXEN +: 2]);
    end
    if (store_en && both) lost_n = 1'b1;
  end

  for (genvar i = 0; i < NBUF; i++) begin : g_wsel
    assign wr_sel[i] = ctl_wr && (view_q == i[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_q <= '0;
      view_q  <= 1'b0;
      lost_q  <= 1'b0;
      rxen_q  <= 1'b0;
      txen_q  <= 1'b0;
    end else begin
      if (store_en || rel) begin
        alloc_q <= alloc_n;
        view_q  <= view_n;
      end
      if (store_en || ctl_wr) lost_q <= lost_n;
      if (ctl_wr) begin
        rxen_q <= rxen_n;
        txen_q <= txen_n;
      end
    end
  end

  assert_single_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_sel));

  assert_view_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && !ctl_wr && alloc_q[view_q]) |-> !ld_sel[view_q]);

  assert_release_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && alloc_q[~view_q]) |=> (view_q != $past(view_q)));

  assert_overwrite_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && !ctl_wr && (&alloc_q)) |=> lost_q);

endmodule

// File: rtl/rxobj_dualbuf.sv
module rxobj_dualbuf
  import rxobj_pkg::*;
#(
  parameter int ID_W       = 29,
  parameter int DATA_BYTES = 8,
  parameter int DLC_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    store_en,
  input  logic [ID_W-1:0]         store_id,
  input  logic                    store_ext,
  input  logic                    store_rtr,
  input  logic [DLC_W-1:0]        store_dlc,
  input  logic [8*DATA_BYTES-1:0] store_data,
  input  logic                    ctl_wr,
  input  logic [CTL_W-1:0]        ctl_wdata,
  output logic [ID_W-1:0]         view_id,
  output logic                    view_ext,
  output logic                    view_rtr,
  output logic [DLC_W-1:0]        view_dlc,
  output logic [8*DATA_BYTES-1:0] view_data,
  output logic                    view_newdat,
  output logic                    view_rmtpnd,
  output logic                    view_intpnd,
  output logic                    msg_lost,
  output logic                    rx_irq
);

  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int PAY_W  = ID_W + 2 + DLC_W + DATA_W;
  localparam int NBUF   = 2;

  logic             rst_s;
  logic             view_sel, rxen;
  logic [NBUF-1:0]  ld_sel, wr_sel, new_v, rmt_v, pend_v;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_v [NBUF];
  logic [PAY_W-1:0] pay_view;

  rxobj_rst_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  rxobj_ctl #(.NBUF(NBUF)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_s),
    .store_en  (store_en),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .view_q    (view_sel),
    .ld_sel    (ld_sel),
    .wr_sel    (wr_sel),
    .lost_q    (msg_lost),
    .rxen_q    (rxen)
  );

  assign pay_in = {store_id, store_ext, store_rtr, store_dlc, store_data};

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    rxobj_slot #(.PAY_W(PAY_W)) i_slot (
      .clk    (clk),
      .rst_n  (rst_s),
      .ld_en  (ld_sel[i]),
      .ld_pay (pay_in),
      .ld_rmt (store_rtr),
      .wr_en  (wr_sel[i]),
      .f_new  (ctl_wdata[POS_NEW +: 2]),
      .f_rmt  (ctl_wdata[POS_RMT +: 2]),
      .f_pend (ctl_wdata[POS_PEND +: 2]),
      .pay_q  (pay_v[i]),
      .new_q  (new_v[i]),
      .rmt_q  (rmt_v[i]),
      .pend_q (pend_v[i])
    );
  end

  assign pay_view = pay_v[view_sel];
  assign {view_id, view_ext, view_rtr, view_dlc, view_data} = pay_view;
  assign view_newdat = new_v[view_sel];
  assign view_rmtpnd = rmt_v[view_sel];
  assign view_intpnd = pend_v[view_sel];
  assign rx_irq      = rxen && (|pend_v);

  assert_irq_on_store_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (store_en && !ctl_wr && rxen) |=> rx_irq);

endmodule

// File: tb/test_rxobj_dualbuf.sv
module test_rxobj_dualbuf;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        store_en = 1'b0;
  logic [28:0] store_id = '0;
  logic        store_ext = 1'b0;
  logic        store_rtr = 1'b0;
  logic [3:0]  store_dlc = '0;
  logic [63:0] store_data = '0;
  logic        ctl_wr = 1'b0;
  logic [11:0] ctl_wdata = '0;
  logic [28:0] view_id;
  logic        view_ext, view_rtr;
  logic [3:0]  view_dlc;
  logic [63:0] view_data;
  logic        view_newdat, view_rmtpnd, view_intpnd, msg_lost, rx_irq;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [11:0] W_REL      = 12'h5FD;
  localparam logic [11:0] W_CLR_PEND = 12'hFFD;
  localparam logic [11:0] W_SET_RXEN = 12'hFFB;
  localparam logic [11:0] W_CLR_RXEN = 12'hFF7;
  localparam logic [11:0] W_SET_TXEN = 12'hFEF;
  localparam logic [11:0] W_CLR_LOST = 12'hF7F;
  localparam logic [11:0] W_CLR_NEW  = 12'h7FF;
  localparam logic [11:0] W_SET_NEW  = 12'hBFF;
  localparam logic [11:0] W_NOP      = 12'h000;

  always #2.5 clk = ~clk;

  rxobj_dualbuf i_rxobj_dualbuf (
    .clk(clk), .rst_n(rst_n), .store_en(store_en), .store_id(store_id),
    .store_ext(store_ext), .store_rtr(store_rtr), .store_dlc(store_dlc),
    .store_data(store_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .view_id(view_id), .view_ext(view_ext), .view_rtr(view_rtr),
    .view_dlc(view_dlc), .view_data(view_data), .view_newdat(view_newdat),
    .view_rmtpnd(view_rmtpnd), .view_intpnd(view_intpnd),
    .msg_lost(msg_lost), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_store(input logic [28:0] id, input logic rtr, input logic [63:0] d);
    @(negedge clk);
    store_en = 1'b1; store_id = id; store_ext = 1'b1; store_rtr = rtr;
    store_dlc = 4'd8; store_data = d;
    @(negedge clk);
    store_en = 1'b0;
  endtask

  task automatic do_write(input logic [11:0] w);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 newdat", view_newdat, 0);
    chk("R1 rmtpnd", view_rmtpnd, 0);
    chk("R1 intpnd", view_intpnd, 0);
    chk("R1 msg_lost", msg_lost, 0);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 data", view_data, 0);
    chk("R1 id", view_id, 0);
  endtask

  task automatic t_first;
    do_write(W_SET_RXEN);
    do_store(29'h100, 1'b0, 64'h1111_2222_3333_4444);
    chk("R3 id", view_id, 29'h100);
    chk("R3 data", view_data, 64'h1111_2222_3333_4444);
    chk("R2 ext", view_ext, 1);
    chk("R2 dlc", view_dlc, 8);
    chk("R2 newdat", view_newdat, 1);
    chk("R2 intpnd", view_intpnd, 1);
    chk("R2 rmtpnd data frame", view_rmtpnd, 0);
    chk("R9 irq", rx_irq, 1);
  endtask

  task automatic t_second;
    do_store(29'h200, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD);
    chk("R4 view id kept", view_id, 29'h100);
    chk("R4 view data kept", view_data, 64'h1111_2222_3333_4444);
    do_write(W_REL);
    chk("R5 view moved id", view_id, 29'h200);
    chk("R5 rtr", view_rtr, 1);
    chk("R2 rmtpnd remote", view_rmtpnd, 1);
    chk("R6 intpnd new view", view_intpnd, 1);
    chk("R6 irq", rx_irq, 1);
  endtask

  task automatic t_third;
    do_store(29'h300, 1'b0, 64'h3);
    chk("R7 view kept", view_id, 29'h200);
    chk("R7 no lost", msg_lost, 0);
    do_store(29'h400, 1'b0, 64'h4);
    chk("R8 lost set", msg_lost, 1);
    chk("R8 view kept", view_id, 29'h200);
    do_write(W_REL);
    chk("R8 newest in view", view_id, 29'h400);
    chk("R8 data", view_data, 64'h4);
    do_write(W_CLR_LOST);
    chk("R8 lost cleared", msg_lost, 0);
  endtask

  task automatic t_fields;
    do_write(W_CLR_NEW);
    chk("R10 newdat cleared", view_newdat, 0);
    chk("R10 no release", view_id, 29'h400);
    do_write(W_NOP);
    chk("R10 00 keeps newdat", view_newdat, 0);
    chk("R10 00 keeps intpnd", view_intpnd, 1);
    do_write(W_SET_NEW);
    chk("R10 newdat set", view_newdat, 1);
    do_store(29'h500, 1'b0, 64'h5);
    chk("R10 still allocated", view_id, 29'h400);
    chk("R10 no lost", msg_lost, 0);
    do_write(W_REL);
    chk("R5 view E", view_id, 29'h500);
  endtask

  task automatic t_irq;
    do_write(W_CLR_PEND);
    chk("R9 irq cleared", rx_irq, 0);
    chk("R6 intpnd cleared", view_intpnd, 0);
    do_write(W_CLR_RXEN);
    do_write(W_SET_TXEN);
    do_store(29'h600, 1'b0, 64'h6);
    chk("R9 txen no effect", rx_irq, 0);
    chk("R7 view kept", view_id, 29'h500);
    do_write(W_SET_RXEN);
    chk("R9 irq enabled", rx_irq, 1);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_first;
    t_second;
    t_third;
    t_fields;
    t_irq;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule